// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register Bank

This block is the control register file of an audio codec, seen from a simple word-addressed bus with single-cycle accesses. The window holds sixteen direct 32-bit registers. One of them supplies a pointer. Another is a data port, through which software reaches thirty-two narrow 8-bit codec registers, one at a time. Software first writes the pointer, then reads or writes the data port.

Some narrow slots have their own access rules. One slot can be written but always reads as zero. Two slots ignore writes. One slot carries a fixed version code and accepts only a single writable bit. On the direct side, one register cannot be written. A control register masks what is stored in it, and setting its lowest bit returns the whole bank to its reset state. The interrupt output is present but is never driven high.

Reads are combinational from the current state. A write takes effect on the rising clock edge at which it is presented.

Top module: `codec_regbank`

## Requirements
- R1: Direct register 0 (byte address 0x00) stores all 32 written bits and reads them back; its low 5 bits are the pointer that selects a narrow register.
- R2: Direct register 1 (byte address 0x04) is the data port. A write stores bits [7:0] of the write data into the narrow register selected by the pointer. A read returns that register zero-extended to 32 bits.
- R3: With the pointer at 3, a data-port read returns 0, whatever was written to that slot.
- R4: Data-port writes with the pointer at 11 or 25 have no effect. Slot 11 always reads 0x00 and slot 25 always reads 0xA0.
- R5: A data-port write with the pointer at 12 stores (write data AND 0x40) OR 0x8A, so slot 12 always reads 0x8A or 0xCA.
- R6: After the active-low reset, every direct register reads 0. Every narrow slot reads 0x00, except slot 12, which reads 0x8A, and slot 25, which reads 0xA0.
- R7: Direct register 2 (byte address 0x08) ignores writes and always reads 0.
- R8: A write to direct register 4 (byte address 0x10) stores only bits [6:0] of the write data. When bit 0 of the write data is 1, every other register also returns to its R6 state on that same edge.
- R9: Direct registers 3 and 5 to 15 store all 32 written bits and read them back unchanged.
- R10: The interrupt output is 0 at all times.
- R11: The register is selected by byte address bits [5:2]; bits [1:0] are ignored. Read data follows the address combinationally. A write shows on the read data only after the clock edge at which it was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address within the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request, held at 0 |

## Verification
A faulty pointer shows up at the data port on the first read after the pointer write: the data comes from the wrong narrow slot. Rule faults in slots 3, 11, 12 and 25 show up on the very next data-port read of that slot, because the expected read value of each of these slots is fixed or limited to two values. A soft reset that misses or over-reaches leaves a direct register or narrow slot that differs from its reset value, and a full read-back sweep right after the control write exposes it. A wrong mask on the control register shows up in bits [31:7] of its own read-back.

// File: rtl/codec_regbank_pkg.sv
// Package: shared constants and slot classification for the codec register bank.
// Assumes the narrow slot numbers and direct register roles below are fixed by
// software convention; only widths and counts are parameters of the modules.
package codec_regbank_pkg;

    // Direct register roles (word index within the window)
    localparam int unsigned REG_INDEX = 0;
    localparam int unsigned REG_DPORT = 1;
    localparam int unsigned REG_RO    = 2;
    localparam int unsigned REG_CTRL  = 4;

    // Narrow slot roles
    localparam int unsigned SLOT_WONLY = 3;
    localparam int unsigned SLOT_ROA   = 11;
    localparam int unsigned SLOT_VER   = 12;
    localparam int unsigned SLOT_ID    = 25;

    // Fixed codes and masks
    localparam logic [7:0]  VER_CODE       = 8'h8A;
    localparam logic [7:0]  ID_CODE        = 8'hA0;
    localparam logic [7:0]  VER_KEEP       = 8'h40;
    localparam logic [31:0] CTRL_KEEP      = 32'h0000_007F;
    localparam int unsigned CTRL_RESET_BIT = 0;

    typedef enum logic [1:0] {
        DK_PLAIN,
        DK_PORT,
        DK_RDONLY,
        DK_CTRL
    } dir_kind_e;

    typedef enum logic [1:0] {
        SK_PLAIN,
        SK_WONLY,
        SK_RDONLY,
        SK_VERSION
    } slot_kind_e;

    // Classify a direct register by its word index
    function automatic dir_kind_e dir_kind_of(input int unsigned r);
        case (r)
            REG_DPORT: return DK_PORT;
            REG_RO:    return DK_RDONLY;
            REG_CTRL:  return DK_CTRL;
            default:   return DK_PLAIN;
        endcase
    endfunction

    // Classify a narrow slot by its number
    function automatic slot_kind_e slot_kind_of(input int unsigned s);
        case (s)
            SLOT_WONLY: return SK_WONLY;
            SLOT_ROA:   return SK_RDONLY;
            SLOT_ID:    return SK_RDONLY;
            SLOT_VER:   return SK_VERSION;
            default:    return SK_PLAIN;
        endcase
    endfunction

    // Reset value of a narrow slot
    function automatic logic [7:0] slot_reset_of(input int unsigned s);
        case (s)
            SLOT_VER: return VER_CODE;
            SLOT_ID:  return ID_CODE;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/crb_addr_decode.sv
// Module: write decoder. Turns the word select and write strobe into one-hot
// per-register write strobes, the data-port write and the soft-reset pulse.
// Assumes DIR_COUNT equals 2**SEL_W so every select value names a register.
module crb_addr_decode
    import codec_regbank_pkg::*;
#(
    parameter int unsigned DIR_COUNT = 16,
    parameter int unsigned SEL_W     = $clog2(DIR_COUNT)
) (
    input  logic                 bus_wr_en,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 reset_bit,
    output logic [DIR_COUNT-1:0] wr_hit,
    output logic                 port_wr,
    output logic                 soft_rst
);

    // One-hot write strobe for the selected direct register
    always_comb begin
        wr_hit = '0;
        if (bus_wr_en) begin
            wr_hit[sel] = 1'b1;
        end
    end

    // Data-port write and soft-reset request derived from the strobes
    always_comb begin
        port_wr  = wr_hit[REG_DPORT];
        soft_rst = wr_hit[REG_CTRL] && reset_bit;
    end

endmodule

// File: rtl/crb_direct_bank.sv
// Module: direct register file. One slot per word of the window, built by
// generate according to its role: plain storage, masked control register,
// or no storage (data port and read-only register, which view as zero here).
// Assumes the soft reset never coincides with a write to a plain register,
// since the soft reset is itself a write to the control register.
module crb_direct_bank
    import codec_regbank_pkg::*;
#(
    parameter int unsigned DIR_COUNT = 16,
    parameter int unsigned DIR_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DIR_COUNT-1:0]            wr_hit,
    input  logic [DIR_W-1:0]                wdata,
    input  logic                            soft_rst,
    output logic [DIR_COUNT-1:0][DIR_W-1:0] view
);

    localparam logic [DIR_W-1:0] CTRL_MASK = DIR_W'(CTRL_KEEP);

    for (genvar g = 0; g < DIR_COUNT; g++) begin : g_reg
        localparam dir_kind_e KIND = dir_kind_of(g);

        if (KIND == DK_PLAIN) begin : g_plain
            logic [DIR_W-1:0] q;
            // Full-width storage, cleared by either reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_hit[g]) begin
                    q <= wdata;
                end else if (soft_rst) begin
                    q <= '0;
                end
            end
            assign view[g] = q;
        end else if (KIND == DK_CTRL) begin : g_ctrl
            logic [DIR_W-1:0] q;
            // Control register keeps only its masked bits, even on soft reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_hit[g]) begin
                    q <= wdata & CTRL_MASK;
                end
            end
            assign view[g] = q;
        end else begin : g_none
            wire hit_unused = wr_hit[g];
            assign view[g] = '0;
        end
    end

endmodule

// File: rtl/crb_indirect_bank.sv
// Module: narrow slot file reached through the data port. Each slot is built
// by generate per its role: plain, write-only (stored but views as zero),
// read-only constant, or version slot with one writable bit.
// Assumes IND_COUNT equals 2**IDX_W and is large enough to hold every role.
module crb_indirect_bank
    import codec_regbank_pkg::*;
#(
    parameter int unsigned IND_COUNT = 32,
    parameter int unsigned IND_W     = 8,
    parameter int unsigned IDX_W     = $clog2(IND_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             port_wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [IND_W-1:0] wdata,
    output logic [IND_W-1:0] rd_data
);

    localparam logic [IND_W-1:0] KEEP = IND_W'(VER_KEEP);
    localparam logic [IND_W-1:0] VER  = IND_W'(VER_CODE);

    logic [IND_COUNT-1:0][IND_W-1:0] view;

    for (genvar g = 0; g < IND_COUNT; g++) begin : g_slot
        localparam slot_kind_e       KIND = slot_kind_of(g);
        localparam logic [IND_W-1:0] RV   = IND_W'(slot_reset_of(g));

        if (KIND == SK_PLAIN) begin : g_plain
            logic             q;
            logic [IND_W-1:0] d;
            assign q = port_wr && (idx == IDX_W'(g));
            // Plain slot: store written byte, clear on either reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d <= RV;
                end else if (q) begin
                    d <= wdata;
                end else if (soft_rst) begin
                    d <= RV;
                end
            end
            assign view[g] = d;
        end else if (KIND == SK_WONLY) begin : g_wonly
            logic             hit;
            logic [IND_W-1:0] store_unused;
            assign hit = port_wr && (idx == IDX_W'(g));
            // Write-only slot: value kept for the converter side, never read back
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store_unused <= RV;
                end else if (hit) begin
                    store_unused <= wdata;
                end else if (soft_rst) begin
                    store_unused <= RV;
                end
            end
            assign view[g] = '0;
        end else if (KIND == SK_VERSION) begin : g_ver
            logic             hit;
            logic [IND_W-1:0] d;
            assign hit = port_wr && (idx == IDX_W'(g));
            // Version slot: one writable bit, version code forced on every write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d <= RV;
                end else if (hit) begin
                    d <= (wdata & KEEP) | VER;
                end else if (soft_rst) begin
                    d <= RV;
                end
            end
            assign view[g] = d;
        end else begin : g_ro
            assign view[g] = RV;
        end
    end

    // Read port: the slot chosen by the current pointer
    always_comb begin
        rd_data = view[idx];
    end

endmodule

// File: rtl/codec_regbank.sv
// Module: top of the codec control register bank. Decodes the word-addressed
// bus, holds the direct registers and the narrow slots, and muxes read data.
// Assumes a single-cycle bus: reads are combinational, writes land on the edge.
module codec_regbank
    import codec_regbank_pkg::*;
#(
    parameter int unsigned DIR_COUNT = 16,
    parameter int unsigned DIR_W     = 32,
    parameter int unsigned IND_COUNT = 32,
    parameter int unsigned IND_W     = 8,
    localparam int unsigned SEL_W    = $clog2(DIR_COUNT),
    localparam int unsigned IDX_W    = $clog2(IND_COUNT),
    localparam int unsigned ADDR_W   = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DIR_W-1:0]  bus_wdata,
    output logic [DIR_W-1:0]  bus_rdata,
    output logic              irq_o
);

    logic [SEL_W-1:0]                sel;
    logic [DIR_COUNT-1:0]            wr_hit;
    logic                            port_wr;
    logic                            soft_rst;
    logic [DIR_COUNT-1:0][DIR_W-1:0] dir_view;
    logic [IDX_W-1:0]                cur_index;
    logic [IND_W-1:0]                ind_rd;

    // Word select from the byte address; the byte lanes are not decoded
    assign sel = bus_addr[ADDR_W-1:2];
    wire addr_lsb_unused = ^bus_addr[1:0];

    crb_addr_decode #(
        .DIR_COUNT (DIR_COUNT),
        .SEL_W     (SEL_W)
    ) dec_i (
        .bus_wr_en (bus_wr_en),
        .sel       (sel),
        .reset_bit (bus_wdata[CTRL_RESET_BIT]),
        .wr_hit    (wr_hit),
        .port_wr   (port_wr),
        .soft_rst  (soft_rst)
    );

    crb_direct_bank #(
        .DIR_COUNT (DIR_COUNT),
        .DIR_W     (DIR_W)
    ) dir_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wdata    (bus_wdata),
        .soft_rst (soft_rst),
        .view     (dir_view)
    );

    // Pointer into the narrow slots
    assign cur_index = dir_view[REG_INDEX][IDX_W-1:0];

    crb_indirect_bank #(
        .IND_COUNT (IND_COUNT),
        .IND_W     (IND_W),
        .IDX_W     (IDX_W)
    ) ind_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .port_wr  (port_wr),
        .idx      (cur_index),
        .wdata    (bus_wdata[IND_W-1:0]),
        .rd_data  (ind_rd)
    );

    // Read mux: data port shows the selected slot, others their own register
    always_comb begin
        if (sel == SEL_W'(REG_DPORT)) begin
            bus_rdata = DIR_W'(ind_rd);
        end else begin
            bus_rdata = dir_view[sel];
        end
    end

    // Interrupt is not used by this bank
    assign irq_o = 1'b0;

endmodule

// File: rtl/codec_regbank_chk.sv
// Module: property checker for the codec register bank, bound to the top.
// Assumes the default layout (pointer in register 0, data port at 1).
module codec_regbank_chk
    import codec_regbank_pkg::*;
#(
    parameter int unsigned DIR_W  = 32,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DIR_W-1:0]  bus_wdata,
    input logic [DIR_W-1:0]  bus_rdata,
    input logic              irq_o,
    input logic [IDX_W-1:0]  cur_index
);

    logic [SEL_W-1:0] c_sel;
    logic             at_port;
    assign c_sel   = bus_addr[ADDR_W-1:2];
    assign at_port = (c_sel == SEL_W'(REG_DPORT));

    assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == 1'b0);

    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && c_sel == SEL_W'(REG_INDEX))
        |=> cur_index == $past(bus_wdata[IDX_W-1:0]));

    assert_port_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        at_port |-> bus_rdata[DIR_W-1:8] == '0);

    assert_wonly_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_port && cur_index == IDX_W'(SLOT_WONLY)) |-> bus_rdata == '0);

    assert_id_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_port && cur_index == IDX_W'(SLOT_ID)) |-> bus_rdata == DIR_W'(ID_CODE));

    assert_roa_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_port && cur_index == IDX_W'(SLOT_ROA)) |-> bus_rdata == '0);

    assert_version_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (at_port && cur_index == IDX_W'(SLOT_VER))
        |-> (bus_rdata & ~DIR_W'(VER_KEEP)) == DIR_W'(VER_CODE));

    assert_rdonly_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sel == SEL_W'(REG_RO)) |-> bus_rdata == '0);

    assert_ctrl_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sel == SEL_W'(REG_CTRL)) |-> (bus_rdata & ~DIR_W'(CTRL_KEEP)) == '0);

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && c_sel == SEL_W'(REG_CTRL) && bus_wdata[CTRL_RESET_BIT])
        |=> cur_index == '0);

endmodule

bind codec_regbank codec_regbank_chk #(
    .DIR_W  (DIR_W),
    .SEL_W  (SEL_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .cur_index (cur_index)
);

// File: tb/codec_regbank_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every direct register and every narrow slot, against a model
// built from the requirements, through resets, soft resets and masked writes.
module codec_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_dir [16];
    logic [7:0]  m_ind [32];

    always #2.5 clk = ~clk;

    codec_regbank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Compare and log one result
    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h got=%h expected=%h", req, bus_addr, got, exp);
        end
    endtask

    // Model: reset state (R6)
    task automatic m_reset();
        for (int i = 0; i < 16; i++) m_dir[i] = '0;
        for (int i = 0; i < 32; i++) m_ind[i] = 8'h00;
        m_ind[12] = 8'h8A;
        m_ind[25] = 8'hA0;
    endtask

    // Model: effect of one write
    task automatic m_write(input logic [5:0] a, input logic [31:0] d);
        int s;
        int ix;
        s  = int'(a[5:2]);
        ix = int'(m_dir[0][4:0]);
        case (s)
            1: begin
                if (ix == 12)                m_ind[ix] = (d[7:0] & 8'h40) | 8'h8A;
                else if (ix != 11 && ix != 25) m_ind[ix] = d[7:0];
            end
            2: ;
            4: begin
                if (d[0]) m_reset();
                m_dir[4] = d & 32'h7F;
            end
            default: m_dir[s] = d;
        endcase
    endtask

    // Model: read value at an address
    function automatic logic [31:0] m_read(input logic [5:0] a);
        int s;
        int ix;
        s  = int'(a[5:2]);
        ix = int'(m_dir[0][4:0]);
        if (s == 1) return (ix == 3) ? 32'h0 : {24'h0, m_ind[ix]};
        return m_dir[s];
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        m_write(a, d);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string req);
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_addr  = a;
        #1;
        check(req, bus_rdata, m_read(a));
    endtask

    task automatic rd_slot(input int i, input string req);
        wr(6'h00, 32'(i));
        rd(6'h04, req);
    endtask

    task automatic sweep_all(input string req);
        for (int k = 0; k < 16; k++) rd(6'(k * 4), req);
        for (int i = 0; i < 32; i++) rd_slot(i, req);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state of all registers and slots
        sweep_all("R6");
        check("R10", 32'(irq_o), 32'h0);

        // R9 / R7 / R1: direct register sweep
        for (int k = 0; k < 16; k++) begin
            if (k != 1 && k != 4) wr(6'(k * 4), 32'h1357_9BDF ^ (32'(k) * 32'h0101_0101));
        end
        for (int k = 0; k < 16; k++) begin
            rd(6'(k * 4), (k == 0) ? "R1" : (k == 2) ? "R7" : "R9");
        end

        // R1 / R2: pointer with junk upper bits, then slot writes
        for (int i = 0; i < 32; i++) begin
            wr(6'h00, 32'hFFFF_FFE0 | 32'(i));
            rd(6'h00, "R1");
            wr(6'h04, 32'hABCD_EF00 | 32'((i * 29 + 7) & 8'hFF));
        end
        for (int i = 0; i < 32; i++) begin
            rd_slot(i, (i == 3) ? "R3" : (i == 11 || i == 25) ? "R4" : (i == 12) ? "R5" : "R2");
        end

        // R5: version slot with bit 6 set and clear
        wr(6'h00, 32'd12);
        wr(6'h04, 32'h0000_00FF);
        rd(6'h04, "R5");
        check("R5", bus_rdata, 32'h0000_00CA);
        wr(6'h04, 32'h0000_0000);
        rd(6'h04, "R5");
        check("R5", bus_rdata, 32'h0000_008A);

        // R3: write-only slot still reads zero after a write
        wr(6'h00, 32'd3);
        wr(6'h04, 32'h0000_00FF);
        rd(6'h04, "R3");
        check("R3", bus_rdata, 32'h0);

        // R4: read-only slots after attempted writes
        wr(6'h00, 32'd25);
        wr(6'h04, 32'h0000_0055);
        rd(6'h04, "R4");
        check("R4", bus_rdata, 32'h0000_00A0);

        // R11: byte lanes ignored; write visible only after the edge
        wr(6'h0E, 32'hCAFE_0001);
        rd(6'h0C, "R11");
        rd(6'h0F, "R11");
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = 6'h0C;
        bus_wdata = 32'h0BAD_F00D;
        #1;
        check("R11", bus_rdata, 32'hCAFE_0001);
        @(posedge clk);
        m_write(6'h0C, 32'h0BAD_F00D);
        #1;
        check("R11", bus_rdata, 32'h0BAD_F00D);
        @(negedge clk);
        bus_wr_en = 1'b0;

        // R8: masked control write without reset bit leaves the bank alone
        wr(6'h10, 32'hFFFF_FFFE);
        rd(6'h10, "R8");
        check("R8", bus_rdata, 32'h0000_007E);
        sweep_all("R8");

        // R8: reset bit clears everything else and stores the masked value
        wr(6'h00, 32'd7);
        wr(6'h04, 32'h0000_0077);
        wr(6'h10, 32'hFFFF_FF81);
        rd(6'h10, "R8");
        check("R8", bus_rdata, 32'h0000_0001);
        sweep_all("R8");

        // R6: hardware reset after fresh writes
        wr(6'h20, 32'h1234_5678);
        wr(6'h00, 32'd9);
        wr(6'h04, 32'h0000_0099);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        sweep_all("R6");
        check("R10", 32'(irq_o), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule